// File: doc/BRIEF.md
# Linear Burst Read Address Sequencer

This block produces the word addresses for a synchronous burst read from a word-addressed memory array. A host presents a start address together with an address strobe. The block samples both at a rising clock edge. It then waits a programmable number of initial-access cycles and delivers one word address per clock, marked by a data-valid strobe. The address stream has no back-pressure. The array side reads one word on every clock where the strobe is high, and the consumer must take each word in that cycle. A ready/busy output tells the host when the stream is stalled.

There are two modes. In fixed-length mode the block issues 8, 16 or 32 consecutive addresses from the start address. It does not wrap inside an aligned group, and it stops once the last word has gone out. In continuous mode it keeps counting and rolls over from the top of the 20-bit space to zero. A burst whose start address is not a multiple of 8 pays a single two-cycle penalty, taken just before the first word whose address is a multiple of 32. The mode and the length are sampled along with the start address and stay fixed for the whole burst.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is low and just after it is released, `word_valid`=0, `ready`=1, `burst_done`=0 and `word_addr`=0.
- R2: If `addr_strobe` is sampled high at an edge with `wait_states`=W, then `word_valid` and `ready` are both 0 for the W cycles that follow. The first word (the start address) is valid in the next cycle after those.
- R3: In fixed mode (`cont_mode`=0 at the strobe), `len_code` 0, 1 and 2 or 3 give 8, 16 and 32 words. Word i carries address start+i, one word per cycle, with no wrap inside any aligned group. Changes to `cont_mode` or `len_code` after the strobe have no effect on the running burst.
- R4: One cycle after the last word of a fixed burst, `burst_done` is 1 for exactly one cycle. From that cycle until the next strobe or stop, `word_valid`=0 and `ready`=0.
- R5: In continuous mode the address rises by one on every valid cycle without limit, and 0xFFFFF is followed by 0x00000.
- R6: When `burst_stop` is high at an edge with no strobe, the block becomes idle from the next cycle: `word_valid`=0, `ready`=1, `burst_done`=0.
- R7: A strobe sampled during a running burst abandons that burst and starts a new one from the new address. The strobe wins over `burst_stop` at the same edge.
- R8: If the start address has bits [2:0] equal to 0, no boundary penalty is inserted, even when the burst passes a multiple of 32.
- R9: If the start address has bits [2:0] not equal to 0, let g = 32 − start[4:0]. Word g is delayed by exactly two cycles, only once per burst, and only if word g is part of the burst. During those two cycles `word_valid`=0, `ready`=0, and `word_addr` holds start+g.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_strobe | input | 1 | Latches `start_addr` and starts a burst |
| start_addr | input | 20 | First word address of the burst |
| burst_stop | input | 1 | Ends the current burst when high |
| cont_mode | input | 1 | 1 = continuous, 0 = fixed length (sampled at the strobe) |
| len_code | input | 2 | Fixed burst length: 0 = 8, 1 = 16, 2 or 3 = 32 words |
| wait_states | input | 3 | Cycles of initial-access latency |
| word_addr | output | 20 | Current word address |
| word_valid | output | 1 | The word at `word_addr` is delivered in this cycle |
| ready | output | 1 | High when idle or delivering, low when stalled or finished |
| burst_done | output | 1 | One-cycle pulse after the last word of a fixed burst |

## Verification
For a strobe at edge k, the registered outputs move after edge k. Word i is therefore due W+i cycles later, plus 2 once i reaches the delayed index g. The completion pulse comes one cycle after the last word, and a stop takes effect one cycle after the edge that samples it. The bench drives inputs on falling edges. It samples every output at the falling edge t cycles after the strobe edge, and compares it with an expected value worked out from W, g and the burst length. Runs sweep every start offset across two 32-word groups for each length and for several wait counts. Separate runs cover wrap, stop and abort.

// File: rtl/bas_pkg.sv
package bas_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_INIT = 3'd1,
    ST_RUN  = 3'd2,
    ST_GAP  = 3'd3,
    ST_DONE = 3'd4
  } bas_state_e;
endpackage

// File: rtl/bas_down_timer.sv
module bas_down_timer #(
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          dec,
  output logic          at_last
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load)                 cnt_q <= load_val;
    else if (dec && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign at_last = (cnt_q == TW'(1));
endmodule

// File: rtl/bas_beat_counter.sv
module bas_beat_counter #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] last_idx,
  output logic          is_last
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (inc)   cnt_q <= cnt_q + 1'b1;
  end

  assign is_last = (cnt_q == last_idx);
endmodule

// File: rtl/bas_addr_step.sv
module bas_addr_step #(
  parameter int AW      = 20,
  parameter int GROUP_W = 5
) (
  input  logic [AW-1:0] cur,
  output logic [AW-1:0] nxt,
  output logic          enters_group
);
  assign nxt          = cur + 1'b1;
  assign enters_group = (nxt[GROUP_W-1:0] == '0);
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int AW         = 20,
  parameter int WS_W       = 3,
  parameter int LEN_W      = 2,
  parameter int GROUP_W    = 5,
  parameter int ALIGN_W    = 3,
  parameter int GAP_CYCLES = 2,
  parameter int MIN_LEN    = 8,
  parameter int MAX_LEN    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_strobe,
  input  logic [AW-1:0]    start_addr,
  input  logic             burst_stop,
  input  logic             cont_mode,
  input  logic [LEN_W-1:0] len_code,
  input  logic [WS_W-1:0]  wait_states,
  output logic [AW-1:0]    word_addr,
  output logic             word_valid,
  output logic             ready,
  output logic             burst_done
);
  localparam int CNT_W = $clog2(MAX_LEN);
  localparam int GAP_W = $clog2(GAP_CYCLES + 1);
  localparam int TW    = (WS_W > GAP_W) ? WS_W : GAP_W;

  bas_state_e        state_q, state_d;
  logic [AW-1:0]     addr_q, addr_d, addr_nxt;
  logic              pend_q, pend_d;
  logic              cont_q;
  logic [CNT_W-1:0]  last_q, len_last;
  logic              done_q, done_d;
  logic              enters_grp, is_last, tmr_last;
  logic              tmr_load;
  logic [TW-1:0]     tmr_val;

  // Length code to index of the final word, capped at the longest burst.
  always_comb begin
    int words;
    words = MIN_LEN << len_code;
    if (words > MAX_LEN) words = MAX_LEN;
    len_last = CNT_W'(words - 1);
  end

  bas_addr_step #(.AW(AW), .GROUP_W(GROUP_W)) u_step (
    .cur          (addr_q),
    .nxt          (addr_nxt),
    .enters_group (enters_grp)
  );

  bas_beat_counter #(.CW(CNT_W)) u_beats (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (addr_strobe),
    .inc      (state_q == ST_RUN && !burst_stop),
    .last_idx (last_q),
    .is_last  (is_last)
  );

  bas_down_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .dec      (state_q == ST_INIT || state_q == ST_GAP),
    .at_last  (tmr_last)
  );

  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    pend_d   = pend_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (addr_strobe) begin
      addr_d   = start_addr;
      pend_d   = |start_addr[ALIGN_W-1:0];
      tmr_load = 1'b1;
      tmr_val  = TW'(wait_states);
      state_d  = (wait_states == '0) ? ST_RUN : ST_INIT;
    end else if (burst_stop) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_INIT: if (tmr_last) state_d = ST_RUN;
        ST_RUN: begin
          if (!cont_q && is_last) begin
            state_d = ST_DONE;
            done_d  = 1'b1;
          end else begin
            addr_d = addr_nxt;
            if (pend_q && enters_grp) begin
              pend_d   = 1'b0;
              state_d  = ST_GAP;
              tmr_load = 1'b1;
              tmr_val  = TW'(GAP_CYCLES);
            end
          end
        end
        ST_GAP:  if (tmr_last) state_d = ST_RUN;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      pend_q  <= 1'b0;
      cont_q  <= 1'b0;
      last_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      pend_q  <= pend_d;
      done_q  <= done_d;
      if (addr_strobe) begin
        cont_q <= cont_mode;
        last_q <= len_last;
      end
    end
  end

  assign word_addr  = addr_q;
  assign word_valid = (state_q == ST_RUN);
  assign ready      = (state_q == ST_RUN) || (state_q == ST_IDLE);
  assign burst_done = done_q;
endmodule

// File: rtl/bas_checker.sv
module bas_checker #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_strobe,
  input logic [AW-1:0] start_addr,
  input logic          burst_stop,
  input logic [AW-1:0] word_addr,
  input logic          word_valid,
  input logic          ready,
  input logic          burst_done
);
  // R2 / R9: a delivered word is never flagged as a stall
  assert_valid_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> ready);

  // R5: consecutive delivered words step by one, with 20-bit rollover
  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !addr_strobe && !burst_stop) |=>
      (!word_valid || word_addr == AW'($past(word_addr) + 1'b1)));

  // R4: completion pulse lasts one cycle and shows a stopped stream
  assert_done_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> (!word_valid && !ready));
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !burst_done);

  // R6: stop without a strobe leaves the block idle
  assert_stop_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_stop && !addr_strobe) |=> (!word_valid && ready && !burst_done));

  // R7: a strobe always reloads the address, whatever else is asserted
  assert_strobe_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strobe |=> (word_addr == $past(start_addr)));
endmodule

bind burst_addr_seq bas_checker #(.AW(AW)) u_bas_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .addr_strobe (addr_strobe),
  .start_addr  (start_addr),
  .burst_stop  (burst_stop),
  .word_addr   (word_addr),
  .word_valid  (word_valid),
  .ready       (ready),
  .burst_done  (burst_done)
);

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
module burst_addr_seq_test;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          addr_strobe = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          burst_stop = 1'b0;
  logic          cont_mode = 1'b0;
  logic [1:0]    len_code = 2'd0;
  logic [2:0]    wait_states = 3'd0;
  logic [AW-1:0] word_addr;
  logic          word_valid, ready, burst_done;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  burst_addr_seq uut (
    .clk, .rst_n, .addr_strobe, .start_addr, .burst_stop, .cont_mode,
    .len_code, .wait_states, .word_addr, .word_valid, .ready, .burst_done
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Compare outputs against the expected state t cycles after the strobe edge.
  task automatic expect_at(input int t, input logic [AW-1:0] st, input int w,
                           input bit cont, input int nwords);
    int g, u, i;
    bit gapped;
    string tag;
    logic exp_v, exp_r, exp_d;
    logic [AW-1:0] exp_a;
    bit chk_a;
    g      = (st[2:0] != 0) ? 32 - int'(st[4:0]) : 1000000;
    gapped = cont ? (g < 1000000) : (g < nwords);
    exp_v = 0; exp_r = 0; exp_d = 0; exp_a = '0; chk_a = 0;
    if (t < w) begin
      tag = "R2";
    end else begin
      u = t - w;
      if (gapped && u >= g && u < g + 2) begin
        tag = "R9"; exp_a = st + AW'(g); chk_a = 1;
      end else begin
        i = (gapped && u >= g + 2) ? u - 2 : u;
        if (cont || i < nwords) begin
          exp_v = 1; exp_r = 1; exp_a = st + AW'(i); chk_a = 1;
          tag = cont ? "R5" : ((st[2:0] == 0) ? "R8" : "R3");
        end else begin
          exp_d = (i == nwords); tag = "R4";
        end
      end
    end
    check({word_valid, ready, burst_done} == {exp_v, exp_r, exp_d}, tag,
          "valid/ready/done", {word_valid, ready, burst_done},
          {exp_v, exp_r, exp_d});
    if (chk_a) check(word_addr == exp_a, tag, "addr", word_addr, exp_a);
  endtask

  task automatic strobe(input logic [AW-1:0] st, input int w, input bit cont,
                        input logic [1:0] code, input bit with_stop);
    @(negedge clk);
    addr_strobe = 1; start_addr = st; wait_states = 3'(w);
    cont_mode = cont; len_code = code; burst_stop = with_stop;
    @(negedge clk);
    addr_strobe = 0; burst_stop = 0;
    // R3: later changes to mode and length must not matter
    cont_mode = ~cont; len_code = ~code;
  endtask

  task automatic run_burst(input logic [AW-1:0] st, input int w,
                           input bit cont, input logic [1:0] code,
                           input int cycles, input bit with_stop);
    int nwords;
    nwords = (code == 0) ? 8 : (code == 1) ? 16 : 32;
    strobe(st, w, cont, code, with_stop);
    for (int t = 0; t < cycles; t++) begin
      expect_at(t, st, w, cont, nwords);
      if (t != cycles - 1) @(negedge clk);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail + 1, n_checks + 1);
    $finish;
  end

  initial begin
    #1;
    // R1: reset values
    check({word_valid, ready, burst_done} == 3'b010, "R1", "in reset",
          {word_valid, ready, burst_done}, 3'b010);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check({word_valid, ready, burst_done} == 3'b010, "R1", "after reset",
          {word_valid, ready, burst_done}, 3'b010);
    check(word_addr == '0, "R1", "addr", word_addr, 0);

    // Example burst: 8 words from 39h crossing into 40h
    run_burst(20'h00039, 0, 0, 2'd0, 14, 0);

    // R2 R3 R4 R8 R9: sweep start offsets, lengths and wait counts
    for (int code = 0; code < 4; code++)
      for (int wi = 0; wi < 3; wi++)
        for (int s = 0; s < 64; s++) begin
          int w;
          w = (wi == 0) ? 0 : (wi == 1) ? 3 : 7;
          run_burst(20'h12340 + AW'(s), w, 0, 2'(code), w + 32 + 6, 0);
        end

    // R5: continuous burst over the top of the space, unaligned start
    run_burst(20'hFFFFA, 1, 1, 2'd0, 50, 0);
    // R5 R8: aligned continuous start, no penalty across many groups
    run_burst(20'hFFFC8, 2, 1, 2'd1, 90, 0);

    // R6: stop ends a continuous burst and the block stays idle
    @(negedge clk); burst_stop = 1;
    @(negedge clk); burst_stop = 0;
    for (int k = 0; k < 3; k++) begin
      check({word_valid, ready, burst_done} == 3'b010, "R6", "idle after stop",
            {word_valid, ready, burst_done}, 3'b010);
      @(negedge clk);
    end
    // R6: stop during a fixed burst's latency window
    strobe(20'h00100, 5, 0, 2'd2, 0);
    burst_stop = 1;
    @(negedge clk); burst_stop = 0;
    for (int k = 0; k < 10; k++) begin
      check({word_valid, ready, burst_done} == 3'b010, "R6", "fixed stopped",
            {word_valid, ready, burst_done}, 3'b010);
      @(negedge clk);
    end

    // R7: abort mid-burst with a new strobe, colliding with a stop
    run_burst(20'h00203, 0, 1, 2'd0, 6, 0);
    run_burst(20'h0051D, 2, 0, 2'd1, 24, 1);
    // R7: restart from the finished state
    run_burst(20'h00010, 0, 0, 2'd0, 12, 0);
    run_burst(20'h00777, 4, 0, 2'd2, 44, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule